// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver

This block is an 8-bit full-duplex serial port driven by a shared clock. Software writes a byte into a single data register. That write starts a transfer: the byte is shifted out on the serial data output while the serial data input is shifted into the same register. When the transfer completes, the register holds the received byte and an interrupt-request flag is raised.

The transfer clock can come from two places. It can be generated inside the block from the system clock through a programmable divider, and in that case it is driven onto the clock pin. It can also come from a peer device on the clock input, where it is synchronised and edge-detected.

Four static controls configure the port:
- clock polarity, which sets the idle level and which edges launch or capture data;
- bit order;
- clock source;
- whether the data pin drives serial output.

A busy flag shows while a transfer is in progress.

Top module: `sync_serial_io`

## Requirements
- R1: After reset, busy and irq are 0, sdo_oe is 0, and sclk_out sits at the idle level for the selected polarity.
- R2: A write while idle sets busy on the next clock. When busy falls, rd_data holds the 8 bits sampled from sdi.
- R3: With the internal clock and no transfer running, sclk_out is 1 when pol_sel=0 and 0 when pol_sel=1.
- R4: Each bit is driven on the leading clock edge (the edge away from idle: falling for pol_sel=0, rising for pol_sel=1) and sampled on the following trailing edge. sdo changes only together with a leading edge.
- R5: With msb_first=0, bit 0 of the written byte goes out first and the first received bit lands in rd_data[0]. With msb_first=1, bit 7 goes out first and the first received bit lands in rd_data[7].
- R6: With the internal clock, every half period lasts div_n+1 system clocks. The first clock edge comes 1 to div_n+1 clocks after the write is registered.
- R7: With the internal clock, sdo_oe equals out_en while busy and is 0 otherwise, so the output floats after a transfer. With the external clock, sdo_oe equals out_en.
- R8: irq is set in the clock in which busy falls. It then stays set until irq_clr is pulsed.
- R9: A write while busy is ignored. The transmitted bits and the received byte are unaffected.
- R10: With ext_clk_sel=1, sclk_oe is 0 and the transfer advances on synchronised edges of sclk_in, using the same leading/trailing rule as R4.
- R11: A transfer ends after exactly 8 trailing edges. With the internal clock this is 16 clock edges in total, and the clock is back at idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Data register write strobe |
| wr_data | input | 8 | Byte to transmit |
| rd_data | output | 8 | Data register (received byte after completion) |
| pol_sel | input | 1 | Clock polarity select |
| msb_first | input | 1 | Bit order select (1 = MSB first) |
| ext_clk_sel | input | 1 | 1 = external transfer clock |
| out_en | input | 1 | Enable serial data output driver |
| div_n | input | 8 | Divider reload; half period = div_n+1 clocks |
| irq_clr | input | 1 | Clears the interrupt request |
| sclk_in | input | 1 | External transfer clock |
| sclk_out | output | 1 | Generated transfer clock |
| sclk_oe | output | 1 | Clock pin output enable |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Serial data output enable |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | Transfer-complete interrupt request |

## Verification
The bench acts as the peer device and goes after four kinds of error.
- Edge direction. A design with swapped edges would capture the byte the peer has not yet presented, so rd_data would come back shifted by one bit.
- Bit order. Bit-order mistakes show up as reversed transmit or receive bytes.
- Clock timing. The bench times every half period and the first-edge latency, which exposes an off-by-one in the divider. It also counts clock edges, so a transfer that ends a bit early or late is caught.
- Ignored writes and output release. A mid-transfer write that restarted the shifter would corrupt both directions. A design that failed to release sdo_oe at the end would leave the output driven.

// File: rtl/ssio_pkg.sv
package ssio_pkg;
    localparam int SSIO_W  = 8;
    localparam int CNT_W   = $clog2(SSIO_W + 1);

    typedef struct packed {
        logic [SSIO_W-1:0] shreg;
        logic              phase;
        logic [CNT_W-1:0]  nbits;
        logic              busy;
        logic              irq;
        logic              sdo;
    } ssio_state_t;
endpackage

// File: rtl/ssio_divider.sv
module ssio_divider #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_n,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q >= div_n);
        cnt_d = tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/ssio_edge_sync.sv
module ssio_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[STAGES-1:0], async_in};
        rise   = pipe_q[STAGES-1] & ~pipe_q[STAGES];
        fall   = ~pipe_q[STAGES-1] & pipe_q[STAGES];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end
endmodule

// File: rtl/sync_serial_io.sv
module sync_serial_io
    import ssio_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SSIO_W-1:0] wr_data,
    output logic [SSIO_W-1:0] rd_data,
    input  logic              pol_sel,
    input  logic              msb_first,
    input  logic              ext_clk_sel,
    input  logic              out_en,
    input  logic [DIV_W-1:0]  div_n,
    input  logic              irq_clr,
    input  logic              sclk_in,
    output logic              sclk_out,
    output logic              sclk_oe,
    input  logic              sdi,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              busy,
    output logic              irq
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(SSIO_W - 1);

    ssio_state_t st_d, st_q;
    logic        div_tick, ext_rise, ext_fall;
    logic        lead_ev, samp_ev;

    ssio_divider #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .div_n (div_n),
        .tick  (div_tick)
    );

    ssio_edge_sync #(.STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (sclk_in),
        .rise     (ext_rise),
        .fall     (ext_fall)
    );

    always_comb begin
        if (ext_clk_sel) begin
            lead_ev = st_q.busy & (pol_sel ? ext_rise : ext_fall);
            samp_ev = st_q.busy & (pol_sel ? ext_fall : ext_rise);
        end else begin
            lead_ev = st_q.busy & div_tick & ~st_q.phase;
            samp_ev = st_q.busy & div_tick &  st_q.phase;
        end
    end

    always_comb begin
        st_d = st_q;
        if (irq_clr) st_d.irq = 1'b0;
        if (!st_q.busy) begin
            st_d.phase = 1'b0;
            if (wr_en) begin
                st_d.shreg = wr_data;
                st_d.busy  = 1'b1;
                st_d.nbits = '0;
            end
        end else begin
            if (lead_ev) begin
                st_d.sdo = msb_first ? st_q.shreg[SSIO_W-1] : st_q.shreg[0];
                if (!ext_clk_sel) st_d.phase = 1'b1;
            end
            if (samp_ev) begin
                st_d.shreg = msb_first ? {st_q.shreg[SSIO_W-2:0], sdi}
                                       : {sdi, st_q.shreg[SSIO_W-1:1]};
                st_d.phase = 1'b0;
                st_d.nbits = st_q.nbits + 1'b1;
                if (st_q.nbits == LAST_BIT) begin
                    st_d.busy = 1'b0;
                    st_d.irq  = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data  = st_q.shreg;
    assign busy     = st_q.busy;
    assign irq      = st_q.irq;
    assign sdo      = st_q.sdo;
    assign sclk_out = ~(pol_sel ^ st_q.phase);
    assign sclk_oe  = ~ext_clk_sel;
    assign sdo_oe   = out_en & (ext_clk_sel | st_q.busy);
endmodule

// File: rtl/sync_serial_io_chk.sv
module sync_serial_io_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       pol_sel,
    input logic       ext_clk_sel,
    input logic       irq_clr,
    input logic       sclk_out,
    input logic       sdo,
    input logic       sdo_oe,
    input logic       busy,
    input logic       irq
);
    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_en) |=> busy);

    p_idle_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !ext_clk_sel) |-> (sclk_out == !pol_sel));

    p_sdo_on_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !ext_clk_sel && $stable(pol_sel) && $stable(sclk_out))
        |-> $stable(sdo));

    p_float_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_clk_sel && !busy) |-> !sdo_oe);

    p_irq_on_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> irq);

    p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);
endmodule

bind sync_serial_io sync_serial_io_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .pol_sel     (pol_sel),
    .ext_clk_sel (ext_clk_sel),
    .irq_clr     (irq_clr),
    .sclk_out    (sclk_out),
    .sdo         (sdo),
    .sdo_oe      (sdo_oe),
    .busy        (busy),
    .irq         (irq)
);

// File: tb/sync_serial_io_tb.sv
module sync_serial_io_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       pol_sel = 1'b0, msb_first = 1'b0, ext_clk_sel = 1'b0, out_en = 1'b1;
    logic [7:0] div_n = 8'd1;
    logic       irq_clr = 1'b0, sclk_in = 1'b1, sdi = 1'b0;
    logic       sclk_out, sclk_oe, sdo, sdo_oe, busy, irq;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    sync_serial_io u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .pol_sel(pol_sel), .msb_first(msb_first), .ext_clk_sel(ext_clk_sel),
        .out_en(out_en), .div_n(div_n), .irq_clr(irq_clr), .sclk_in(sclk_in),
        .sclk_out(sclk_out), .sclk_oe(sclk_oe), .sdi(sdi), .sdo(sdo),
        .sdo_oe(sdo_oe), .busy(busy), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int bit_idx(input int k, input bit msb);
        return msb ? 7 - k : k;
    endfunction

    task automatic write_byte(input logic [7:0] b);
        wr_data = b; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic clear_irq();
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
    endtask

    // Internal-clock transfer; bench plays the peer. Optional stray write mid-transfer.
    task automatic run_int(input logic [7:0] tx, input logic [7:0] rx, input bit pol,
                           input bit msb, input logic [7:0] n, input bit stray);
        logic [7:0] got_tx = '0;
        logic       prev, idle;
        int cyc = 0, last = 0, edges = 0, leads = 0;
        bit ok_lat = 1, ok_half = 1, ok_oe = 1;
        ext_clk_sel = 1'b0; pol_sel = pol; msb_first = msb; div_n = n;
        @(negedge clk);
        idle = ~pol;
        check(sclk_out == idle, "R3", sclk_out, idle);
        write_byte(tx);
        check(busy == 1'b1, "R2", busy, 1);
        prev = sclk_out;
        while (busy && cyc < 5000) begin
            @(negedge clk);
            cyc++;
            if (busy && sdo_oe != 1'b1) ok_oe = 0;
            if (sclk_out != prev) begin
                if (edges == 0) begin
                    if (cyc < 1 || cyc > int'(n) + 1) ok_lat = 0;
                end else if (cyc - last != int'(n) + 1) ok_half = 0;
                last = cyc;
                if (sclk_out != idle) begin
                    got_tx[bit_idx(leads, msb)] = sdo;
                    sdi = rx[bit_idx(leads, msb)];
                    leads++;
                    if (stray && leads == 3) write_byte(~tx);
                    if (stray && leads == 3) cyc++;
                end
                edges++;
                prev = sclk_out;
            end
        end
        check(ok_lat, "R6 first-edge latency", ok_lat, 1);
        check(ok_half, "R6 half period", ok_half, 1);
        check(edges == 16, "R11 edge count", edges, 16);
        check(sclk_out == idle, "R11 clock back at idle", sclk_out, idle);
        check(got_tx == tx, stray ? "R9 tx after stray write" : "R4/R5 tx bits", got_tx, tx);
        check(rd_data == rx, stray ? "R9 rx after stray write" : "R5 rx byte", rd_data, rx);
        check(irq == 1'b1, "R8 irq set", irq, 1);
        check(ok_oe, "R7 oe while busy", ok_oe, 1);
        check(sdo_oe == 1'b0, "R7 float after", sdo_oe, 0);
        clear_irq();
    endtask

    // External-clock transfer driven by the bench on sclk_in.
    task automatic run_ext(input logic [7:0] tx, input logic [7:0] rx, input bit pol, input bit msb);
        logic [7:0] got_tx = '0;
        ext_clk_sel = 1'b1; pol_sel = pol; msb_first = msb;
        sclk_in = ~pol;
        repeat (6) @(negedge clk);
        check(sclk_oe == 1'b0, "R10 clock pin input", sclk_oe, 0);
        check(sdo_oe == out_en, "R7 ext oe", sdo_oe, out_en);
        write_byte(tx);
        for (int k = 0; k < 8; k++) begin
            sclk_in = pol;
            repeat (6) @(negedge clk);
            got_tx[bit_idx(k, msb)] = sdo;
            sdi = rx[bit_idx(k, msb)];
            if (k == 7) check(busy == 1'b1, "R11 busy before 8th sample", busy, 1);
            sclk_in = ~pol;
            repeat (6) @(negedge clk);
        end
        check(busy == 1'b0, "R11 ext done", busy, 0);
        check(got_tx == tx, "R10 ext tx bits", got_tx, tx);
        check(rd_data == rx, "R10 ext rx byte", rd_data, rx);
        check(irq == 1'b1, "R8 ext irq", irq, 1);
        clear_irq();
        ext_clk_sel = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R1 busy", busy, 0);
        check(irq == 1'b0, "R1 irq", irq, 0);
        check(sdo_oe == 1'b0, "R1 sdo_oe", sdo_oe, 0);
        check(sclk_out == 1'b1, "R1 idle clock", sclk_out, 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(sclk_out == 1'b1, "R3 pol0 idle high", sclk_out, 1);
        pol_sel = 1'b1; #1;
        check(sclk_out == 1'b0, "R3 pol1 idle low", sclk_out, 0);
        // directed corners
        run_int(8'hA5, 8'h3C, 0, 0, 8'd0, 0);
        run_int(8'h81, 8'h7E, 1, 1, 8'd3, 0);
        run_int(8'hF0, 8'h0F, 0, 1, 8'd255, 0);
        run_int(8'h5A, 8'hC3, 1, 0, 8'd2, 1);
        // irq held until cleared
        run_int(8'h12, 8'h34, 0, 0, 8'd1, 0);
        write_byte(8'h00);
        while (busy) @(negedge clk);
        repeat (5) @(negedge clk);
        check(irq == 1'b1, "R8 irq held", irq, 1);
        clear_irq();
        check(irq == 1'b0, "R8 irq cleared", irq, 0);
        run_ext(8'hC6, 8'h9B, 0, 0);
        run_ext(8'h3D, 8'h62, 1, 1);
        // constrained random
        for (int i = 0; i < 20; i++) begin
            run_int(8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom),
                    8'($urandom_range(0, 5)), 1'($urandom_range(0, 3) == 0));
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule